// File: doc/BRIEF.md
# Bank-Select Memory Card Decoder

This block decides, for a 64 KiB memory card on a bus with 24-bit addressing, whether the card answers the current memory cycle and which of its four 16 KiB blocks may be driven. Two board-select schemes are available, chosen by a static mode input. In port mode, software writes a byte to I/O port 40h. Each card on the bus watches one bit of that byte, so up to eight cards share the port and any mix of them can be switched in at once. In address mode, the upper address byte (A23..A16) is compared with an 8-bit board number, so up to 256 cards can sit on the bus. A narrow option restricts that compare to A19..A16.

On top of board selection, each 16 KiB block has a disable switch. An active-low phantom line forces the whole card off, unless the phantom feature is turned off. The outputs are one enable per block and a single card select, which is asserted only during a memory cycle that lands in an enabled block of a selected card. The port register is clocked. The outputs follow the inputs combinationally.

Top module: `bsel_mem_decoder`

## Requirements
- R1: While reset is low, and after it is released, the port register holds zero, so a card in port mode (`addr_mode`=0) drives `card_sel`=0 and `blk_en`=0 until software sets its bit.
- R2: A write to the port register happens at the first clock edge where `io_wr` is sampled high after being sampled low, and only if `io_port` equals 40h at that edge. The register then takes `io_data`. In port mode the card is selected when bit `board_id[2:0]` of the register is 1.
- R3: A rising `io_wr` while `io_port` is not 40h leaves the register unchanged.
- R4: While `io_wr` stays high, later changes of `io_data` do not reload the register. Only a new low-to-high transition does.
- R5: In address mode (`addr_mode`=1) with `narrow_cmp`=0, the card is selected exactly when `bus_addr[23:16]` equals `board_id[7:0]`.
- R6: In address mode with `narrow_cmp`=1, only `bus_addr[19:16]` is compared with `board_id[3:0]`. Bits 23..20 have no effect.
- R7: `blk_en[i]` is 1 only when the card is selected and `blk_off[i]` is 0. Block i covers addresses whose `bus_addr[15:14]` equals i.
- R8: When `phantom_en`=1 and `phantom_n`=0, all `blk_en` bits and `card_sel` are 0. When `phantom_en`=0, `phantom_n` has no effect.
- R9: `card_sel` equals `mem_cycle` AND `blk_en[bus_addr[15:14]]`, so it is never asserted outside a memory cycle.
- R10: In port mode the upper address bits have no effect on selection. In address mode the port register contents have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the port register and strobe edge detection |
| rst_n | input | 1 | Asynchronous active-low reset; clears the port register |
| bus_addr | input | 24 | Bus address A23..A0 |
| mem_cycle | input | 1 | High during a memory cycle |
| io_wr | input | 1 | I/O write strobe, active high |
| io_port | input | 8 | Low byte of the I/O port address |
| io_data | input | 8 | Data-out bus during I/O writes |
| phantom_n | input | 1 | Phantom line, active low |
| phantom_en | input | 1 | 1 = phantom line honoured |
| addr_mode | input | 1 | 0 = port-register select, 1 = address compare |
| board_id | input | 8 | Board number; bits 2..0 pick the register bit in port mode |
| narrow_cmp | input | 1 | 1 = compare A19..A16 only |
| blk_off | input | 4 | Per-block disable, bit i for block i |
| card_sel | output | 1 | Card answers this memory cycle |
| blk_en | output | 4 | Per-block enable to the memory array |

## Verification
On every cycle the assertions check that `card_sel` never rises outside a memory cycle or in a disabled block, that an asserted phantom line leaves no block enabled, that a disabled block is never enabled, and that the port register changes only on a qualified strobe edge. Which bit of the register a card follows, what the register holds after reset, how the full and narrow address compares treat the upper bits, and the fact that a strobe held high does not reload the register are shown only by the bench's directed scenarios. In those scenarios the expected selection is worked out from the written rules.

// File: rtl/bsel_pkg.sv
package bsel_pkg;

  // Extended board compare: full byte, or low nibble only.
  function automatic logic ext_match(input logic [7:0] hi_addr,
                                     input logic [7:0] id,
                                     input logic       narrow);
    if (narrow) return hi_addr[3:0] == id[3:0];
    return hi_addr == id;
  endfunction

  // Pick one bit of the port register.
  function automatic logic reg_bit(input logic [7:0] val,
                                   input logic [2:0] pos);
    return val[pos];
  endfunction

endpackage

// File: rtl/bsel_port_latch.sv
module bsel_port_latch #(
  parameter int          DATA_W  = 8,
  parameter int          PORT_W  = 8,
  parameter logic [7:0]  PORT_ID = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_port,
  input  logic [DATA_W-1:0] io_data,
  output logic [DATA_W-1:0] latch_q,
  output logic              ev_load
);
  logic wr_q;
  logic wr_rise;

  assign wr_rise = io_wr & ~wr_q;
  assign ev_load = wr_rise & (io_port == PORT_W'(PORT_ID));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      latch_q <= '0;
    end else begin
      wr_q <= io_wr;
      if (ev_load) latch_q <= io_data;
    end
  end
endmodule

// File: rtl/bsel_board_hit.sv
module bsel_board_hit
  import bsel_pkg::*;
(
  input  logic       addr_mode,
  input  logic       narrow_cmp,
  input  logic [7:0] latch_q,
  input  logic [7:0] board_id,
  input  logic [7:0] ext_addr,
  output logic       board_hit
);
  logic hit_port;
  logic hit_addr;

  assign hit_port  = reg_bit(latch_q, board_id[2:0]);
  assign hit_addr  = ext_match(ext_addr, board_id, narrow_cmp);
  assign board_hit = addr_mode ? hit_addr : hit_port;
endmodule

// File: rtl/bsel_block_gate.sv
module bsel_block_gate #(
  parameter int BLK_CNT = 4,
  parameter int BLK_W   = $clog2(BLK_CNT)
) (
  input  logic               board_hit,
  input  logic               phantom_n,
  input  logic               phantom_en,
  input  logic               mem_cycle,
  input  logic [BLK_CNT-1:0] blk_off,
  input  logic [BLK_W-1:0]   blk_idx,
  output logic [BLK_CNT-1:0] blk_en,
  output logic               card_sel
);
  logic ghost;

  assign ghost = phantom_en & ~phantom_n;

  for (genvar g = 0; g < BLK_CNT; g++) begin : g_blk
    assign blk_en[g] = board_hit & ~blk_off[g] & ~ghost;
  end

  assign card_sel = mem_cycle & blk_en[blk_idx];
endmodule

// File: rtl/bsel_mem_decoder.sv
module bsel_mem_decoder #(
  parameter int ADDR_W  = 24,
  parameter int BLK_CNT = 4,
  parameter int CARD_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [23:0]        bus_addr,
  input  logic               mem_cycle,
  input  logic               io_wr,
  input  logic [7:0]         io_port,
  input  logic [7:0]         io_data,
  input  logic               phantom_n,
  input  logic               phantom_en,
  input  logic               addr_mode,
  input  logic [7:0]         board_id,
  input  logic               narrow_cmp,
  input  logic [3:0]         blk_off,
  output logic               card_sel,
  output logic [3:0]         blk_en
);
  localparam int BLK_W = $clog2(BLK_CNT);

  logic [7:0]       latch_q;
  logic             ev_load;
  logic             board_hit;
  logic [BLK_W-1:0] blk_idx;
  logic [7:0]       ext_addr;

  assign ext_addr = bus_addr[ADDR_W-1 -: 8];
  assign blk_idx  = bus_addr[CARD_W-1 -: BLK_W];

  bsel_port_latch #(.DATA_W(8), .PORT_W(8), .PORT_ID(8'h40)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .io_wr   (io_wr),
    .io_port (io_port),
    .io_data (io_data),
    .latch_q (latch_q),
    .ev_load (ev_load)
  );

  bsel_board_hit u_hit (
    .addr_mode  (addr_mode),
    .narrow_cmp (narrow_cmp),
    .latch_q    (latch_q),
    .board_id   (board_id),
    .ext_addr   (ext_addr),
    .board_hit  (board_hit)
  );

  bsel_block_gate #(.BLK_CNT(BLK_CNT)) u_gate (
    .board_hit  (board_hit),
    .phantom_n  (phantom_n),
    .phantom_en (phantom_en),
    .mem_cycle  (mem_cycle),
    .blk_off    (blk_off),
    .blk_idx    (blk_idx),
    .blk_en     (blk_en),
    .card_sel   (card_sel)
  );
endmodule

// File: rtl/bsel_mem_decoder_chk.sv
module bsel_mem_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_cycle,
  input logic       card_sel,
  input logic [3:0] blk_en,
  input logic [3:0] blk_off,
  input logic       phantom_n,
  input logic       phantom_en,
  input logic [7:0] latch_q,
  input logic       ev_load
);
  p_sel_needs_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cycle |-> !card_sel);

  p_phantom_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phantom_en && !phantom_n) |-> (blk_en == 4'b0));

  p_off_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_en & blk_off) == 4'b0);

  p_sel_has_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    card_sel |-> (blk_en != 4'b0));

  p_reg_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_load |=> $stable(latch_q));
endmodule

bind bsel_mem_decoder bsel_mem_decoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_cycle  (mem_cycle),
  .card_sel   (card_sel),
  .blk_en     (blk_en),
  .blk_off    (blk_off),
  .phantom_n  (phantom_n),
  .phantom_en (phantom_en),
  .latch_q    (latch_q),
  .ev_load    (ev_load)
);

// File: tb/bsel_mem_decoder_tb.sv
module bsel_mem_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        mem_cycle = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_port = '0;
  logic [7:0]  io_data = '0;
  logic        phantom_n = 1'b1;
  logic        phantom_en = 1'b1;
  logic        addr_mode = 1'b0;
  logic [7:0]  board_id = '0;
  logic        narrow_cmp = 1'b0;
  logic [3:0]  blk_off = '0;
  logic        card_sel;
  logic [3:0]  blk_en;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsel_mem_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .mem_cycle(mem_cycle),
    .io_wr(io_wr), .io_port(io_port), .io_data(io_data),
    .phantom_n(phantom_n), .phantom_en(phantom_en), .addr_mode(addr_mode),
    .board_id(board_id), .narrow_cmp(narrow_cmp), .blk_off(blk_off),
    .card_sel(card_sel), .blk_en(blk_en)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected outputs given whether the board is selected.
  function automatic logic [3:0] exp_en(input logic sel);
    if (!sel || (phantom_en && !phantom_n)) return 4'b0;
    return ~blk_off;
  endfunction

  task automatic port_write(input logic [7:0] port, input logic [7:0] data);
    @(negedge clk);
    io_port = port; io_data = data; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle;
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; addr_mode = 1'b0; mem_cycle = 1'b1;
    board_id = 8'd3; bus_addr = 24'h00_4000;
    repeat (2) @(negedge clk);
    check("R1 card_sel in reset", {7'b0, card_sel}, 8'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 blk_en after reset", {4'b0, blk_en}, 8'h0);
    check("R1 card_sel after reset", {7'b0, card_sel}, 8'h0);
  endtask

  task automatic t_port_select;
    addr_mode = 1'b0; mem_cycle = 1'b1; bus_addr = 24'h00_8000;
    for (int b = 0; b < 8; b++) begin
      board_id = 8'(b);
      port_write(8'h40, 8'h01 << b);
      check("R2 selected on own bit", {4'b0, blk_en}, {4'b0, exp_en(1'b1)});
      check("R2 card_sel own bit", {7'b0, card_sel}, 8'h1);
      board_id = 8'((b + 1) % 8);
      settle();
      check("R2 other bit clear", {4'b0, blk_en}, 8'h0);
    end
  endtask

  task automatic t_other_port;
    addr_mode = 1'b0; board_id = 8'd5; mem_cycle = 1'b1;
    port_write(8'h40, 8'h20);
    port_write(8'h41, 8'h00);
    check("R3 port 41h ignored", {7'b0, card_sel}, 8'h1);
    port_write(8'hC0, 8'h00);
    check("R3 port C0h ignored", {7'b0, card_sel}, 8'h1);
  endtask

  task automatic t_held_strobe;
    addr_mode = 1'b0; board_id = 8'd2; mem_cycle = 1'b1;
    @(negedge clk);
    io_port = 8'h40; io_data = 8'h04; io_wr = 1'b1;
    @(negedge clk);
    check("R4 first edge loads", {7'b0, card_sel}, 8'h1);
    io_data = 8'h00;
    repeat (3) @(negedge clk);
    check("R4 held strobe no reload", {7'b0, card_sel}, 8'h1);
    io_wr = 1'b0;
    @(negedge clk);
    io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    check("R4 new edge reloads", {7'b0, card_sel}, 8'h0);
  endtask

  task automatic t_addr_full;
    addr_mode = 1'b1; narrow_cmp = 1'b0; mem_cycle = 1'b1; board_id = 8'hA5;
    port_write(8'h40, 8'h00);
    bus_addr = 24'hA5_0000; settle();
    check("R5 exact match", {7'b0, card_sel}, 8'h1);
    check("R10 register ignored in addr mode", {4'b0, blk_en}, {4'b0, exp_en(1'b1)});
    bus_addr = 24'h25_0000; settle();
    check("R5 bit23 differs", {7'b0, card_sel}, 8'h0);
    bus_addr = 24'hA4_0000; settle();
    check("R5 bit16 differs", {4'b0, blk_en}, 8'h0);
  endtask

  task automatic t_addr_narrow;
    addr_mode = 1'b1; narrow_cmp = 1'b1; mem_cycle = 1'b1; board_id = 8'h37;
    bus_addr = 24'hF7_C000; settle();
    check("R6 upper nibble ignored", {7'b0, card_sel}, 8'h1);
    bus_addr = 24'h06_C000; settle();
    check("R6 low nibble differs", {7'b0, card_sel}, 8'h0);
    narrow_cmp = 1'b0;
    bus_addr = 24'hF7_C000; settle();
    check("R5 full compare rejects", {7'b0, card_sel}, 8'h0);
  endtask

  task automatic t_block_disable;
    addr_mode = 1'b1; narrow_cmp = 1'b0; board_id = 8'h12; mem_cycle = 1'b1;
    for (int m = 0; m < 16; m++) begin
      blk_off = 4'(m);
      for (int k = 0; k < 4; k++) begin
        bus_addr = {8'h12, 2'(k), 14'h0123};
        settle();
        check("R7 block enable", {4'b0, blk_en}, {4'b0, exp_en(1'b1)});
        check("R7 card_sel by block", {7'b0, card_sel}, {7'b0, ~blk_off[k]});
      end
    end
    blk_off = 4'b0;
  endtask

  task automatic t_phantom;
    addr_mode = 1'b1; board_id = 8'h12; bus_addr = 24'h12_4000; mem_cycle = 1'b1;
    phantom_en = 1'b1; phantom_n = 1'b0; settle();
    check("R8 phantom blanks blocks", {4'b0, blk_en}, 8'h0);
    check("R8 phantom blanks card_sel", {7'b0, card_sel}, 8'h0);
    phantom_en = 1'b0; settle();
    check("R8 phantom feature off", {4'b0, blk_en}, 8'h0F);
    phantom_n = 1'b1; phantom_en = 1'b1; settle();
    check("R8 phantom inactive", {7'b0, card_sel}, 8'h1);
  endtask

  task automatic t_mem_cycle;
    addr_mode = 1'b1; board_id = 8'h12; bus_addr = 24'h12_4000;
    mem_cycle = 1'b0; settle();
    check("R9 no cycle no select", {7'b0, card_sel}, 8'h0);
    check("R9 blocks still enabled", {4'b0, blk_en}, 8'h0F);
    mem_cycle = 1'b1; settle();
    check("R9 cycle selects", {7'b0, card_sel}, 8'h1);
  endtask

  task automatic t_port_ignores_addr;
    addr_mode = 1'b0; board_id = 8'd6; mem_cycle = 1'b1;
    port_write(8'h40, 8'h40);
    bus_addr = 24'h00_0000; settle();
    check("R10 addr 00 in port mode", {7'b0, card_sel}, 8'h1);
    bus_addr = 24'hFF_0000; settle();
    check("R10 addr FF in port mode", {7'b0, card_sel}, 8'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_port_select();
    t_other_port();
    t_held_strobe();
    t_addr_full();
    t_addr_narrow();
    t_block_disable();
    t_phantom();
    t_mem_cycle();
    t_port_ignores_addr();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule